// File: doc/BRIEF.md
# Single-Cycle Integer Core with Post-Increment Load

This block is a small integer processor core that completes one instruction per clock: it fetches, decodes, executes and writes back in the same cycle. It handles register-to-register arithmetic and logic, a left shift by a constant amount, load and store of words, equality branches, jumps through a register and loading an upper immediate. It also has a load that walks through memory: one instruction loads a word and steps its index register by one.

Instruction words come from a ROM port with synchronous read. The core drives `imemAddr` with the address of the next instruction, and that word arrives on `imemData` after the following clock edge. Data memory is read combinationally and written on the clock edge. A control decoder turns the opcode and function fields into a bundle of strobes. The datapath holds the program counter, the ALU and a 32-entry register file. The register file has two write ports, so the post-increment load can update two registers in one cycle.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `pc` and `imemAddr` are 0 and `dmemWe` and `dmemRe` are 0. After release, the first instruction executed is the word at address 0.
- R2: Register-format instructions (opcode 0x00; bits 25:21 first source, 20:16 second source, 15:11 destination) compute add (function 0x20), subtract (0x22), and (0x24), or (0x25) and signed set-less-than (0x2A), and write the result into the destination register.
- R3: A load (opcode 0x23) asserts `dmemRe` and writes the word at address source + sign-extended bits 15:0 into the register named by bits 20:16.
- R4: A store (opcode 0x2B) writes the register named by bits 20:16 to address source + sign-extended offset. It asserts `dmemWe` and changes no register.
- R5: A branch (opcode 0x04) with equal operands sets the next PC to PC+4 plus the sign-extended offset times 4. With unequal operands it falls through to PC+4.
- R6: Register jump (opcode 0x00, function 0x08) loads the PC from the register in bits 25:21 and writes no register, whatever bits 15:11 hold.
- R7: Shift (opcode 0x00, function 0x00) writes the register in bits 20:16, shifted left by bits 10:6, into the register in bits 15:11.
- R8: Upper-immediate load (opcode 0x0F) writes bits 15:0 into the upper half of the register in bits 20:16, with zeros in the lower half.
- R9: Post-increment load (opcode 0x30) reads the word at sign-extended bits 15:0 plus the index register (bits 20:16). It writes that word into the register in bits 25:21 and writes index+1 into the index register, in the same cycle.
- R10: When the post-increment load names the same register for data and index, that register receives index+1.
- R11: Register 0 reads as zero, and writes to it are dropped.
- R12: Any instruction other than a taken branch or a register jump advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 32 | Byte address of the instruction to fetch at the next edge |
| imemData | input | 32 | Instruction word registered by the ROM at the previous edge |
| dmemAddr | output | 32 | Data memory address |
| dmemWData | output | 32 | Store data |
| dmemRData | input | 32 | Combinational load data |
| dmemWe | output | 1 | Store strobe |
| dmemRe | output | 1 | Load strobe |
| pc | output | 32 | Address of the instruction currently executing |

## Verification
The assertions assume a ROM that returns, after each edge, the word at the address `imemAddr` showed before that edge. They also assume load data that settles within the cycle and a reset held across at least one edge, so that the instruction register and PC are known once it falls. The bench keeps to these assumptions with a registered ROM model and a combinational data memory model, both indexed by low address bits. Every program uses only the decoded opcodes, keeps addresses small, and ends in a branch to itself, so execution never leaves the loaded image.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int OPW  = 6;

  localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPW-1:0] OP_LW    = 6'h23;
  localparam logic [OPW-1:0] OP_SW    = 6'h2B;
  localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPW-1:0] OP_LUI   = 6'h0F;
  localparam logic [OPW-1:0] OP_LDINC = 6'h30;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_SUB   = 2'b01,
    ALU_FUNCT = 2'b10,
    ALU_UPPER = 2'b11
  } aluSel_e;

  typedef struct packed {
    logic    regDst;
    logic    aluSrc;
    logic    memToReg;
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    branch;
    aluSel_e aluOp;
    logic    jumpReg;
    logic    dstFromRs;
    logic    baseFromRt;
    logic    incWrite;
  } ctrl_t;
endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_core_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic [5:0]     funct,
  output ctrl_t          ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    if (!rst) begin
      unique case (opcode)
        OP_RTYPE: begin
          ctrl.regDst   = 1'b1;
          ctrl.aluOp    = ALU_FUNCT;
          ctrl.jumpReg  = (funct == FN_JR);
          ctrl.regWrite = (funct != FN_JR);
        end
        OP_LW: begin
          ctrl.aluSrc   = 1'b1;
          ctrl.memToReg = 1'b1;
          ctrl.regWrite = 1'b1;
          ctrl.memRead  = 1'b1;
        end
        OP_SW: begin
          ctrl.aluSrc   = 1'b1;
          ctrl.memWrite = 1'b1;
        end
        OP_BEQ: begin
          ctrl.branch = 1'b1;
          ctrl.aluOp  = ALU_SUB;
        end
        OP_LUI: begin
          ctrl.aluSrc   = 1'b1;
          ctrl.regWrite = 1'b1;
          ctrl.aluOp    = ALU_UPPER;
        end
        OP_LDINC: begin
          ctrl.aluSrc     = 1'b1;
          ctrl.memToReg   = 1'b1;
          ctrl.regWrite   = 1'b1;
          ctrl.memRead    = 1'b1;
          ctrl.dstFromRs  = 1'b1;
          ctrl.baseFromRt = 1'b1;
          ctrl.incWrite   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.memRead, ctrl.memWrite, ctrl.branch, ctrl.jumpReg})); // R4
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !ctrl.regWrite && !ctrl.incWrite); // R4
  AST_JR_NO_WB: assert property (@(posedge clk) disable iff (rst)
    ctrl.jumpReg |-> !ctrl.regWrite); // R6
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  aluSel_e      aluOp,
  input  logic [5:0]   funct,
  input  logic [4:0]   shamt,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         isZero
);
  localparam int HALF = W / 2;
  logic lessThan;

  assign lessThan = $signed(opA) < $signed(opB);

  always_comb begin
    unique case (aluOp)
      ALU_ADD:   result = opA + opB;
      ALU_SUB:   result = opA - opB;
      ALU_UPPER: result = opB << HALF;
      default: begin
        unique case (funct)
          FN_ADD:  result = opA + opB;
          FN_SUB:  result = opA - opB;
          FN_AND:  result = opA & opB;
          FN_OR:   result = opA | opB;
          FN_SLT:  result = {{(W-1){1'b0}}, lessThan};
          FN_SLL:  result = opB << shamt;
          default: result = '0;
        endcase
      end
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEnA,
  input  logic [AW-1:0] wrAddrA,
  input  logic [W-1:0]  wrDataA,
  input  logic          wrEnB,
  input  logic [AW-1:0] wrAddrB,
  input  logic [W-1:0]  wrDataB
);
  localparam int NREG = 1 << AW;
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (wrEnA && wrAddrA != '0) regs[wrAddrA] <= wrDataA;
      if (wrEnB && wrAddrB != '0) regs[wrAddrB] <= wrDataB;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

  logic          lastBValid;
  logic [AW-1:0] lastBAddr;
  logic [W-1:0]  lastBData;
  always_ff @(posedge clk) begin
    if (rst) begin
      lastBValid <= 1'b0;
      lastBAddr  <= '0;
      lastBData  <= '0;
    end else begin
      lastBValid <= wrEnB && wrAddrB != '0;
      lastBAddr  <= wrAddrB;
      lastBData  <= wrDataB;
    end
  end

  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0); // R11
  AST_PORTB_WINS: assert property (@(posedge clk) disable iff (rst)
    lastBValid |-> regs[lastBAddr] == lastBData); // R10
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic           clk,
  input  logic           rst,
  input  ctrl_t          ctrl,
  input  logic [W-1:0]   instr,
  input  logic [W-1:0]   dmemRData,
  output logic [OPW-1:0] opcode,
  output logic [5:0]     funct,
  output logic [W-1:0]   pc,
  output logic [W-1:0]   imemAddr,
  output logic [W-1:0]   dmemAddr,
  output logic [W-1:0]   dmemWData
);
  localparam int IMMW = 16;

  logic [RIDX-1:0] rsIdx, rtIdx, rdIdx, wrIdx;
  logic [4:0]      shamt;
  logic [W-1:0]    immExt, rsVal, rtVal, opA, opB, aluRes, wrData;
  logic [W-1:0]    pcPlus4, brTarget, nextPc;
  logic            aluZero, taken;

  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign immExt = {{(W-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};

  sc_regfile #(.W(W), .AW(RIDX)) regs_i (
    .clk(clk), .rst(rst),
    .rdAddrA(rsIdx), .rdAddrB(rtIdx),
    .rdDataA(rsVal), .rdDataB(rtVal),
    .wrEnA(ctrl.regWrite), .wrAddrA(wrIdx), .wrDataA(wrData),
    .wrEnB(ctrl.incWrite), .wrAddrB(rtIdx), .wrDataB(rtVal + 1'b1)
  );

  assign opA = ctrl.baseFromRt ? rtVal : rsVal;
  assign opB = ctrl.aluSrc ? immExt : rtVal;

  sc_alu #(.W(W)) alu_i (
    .aluOp(ctrl.aluOp), .funct(funct), .shamt(shamt),
    .opA(opA), .opB(opB), .result(aluRes), .isZero(aluZero)
  );

  assign wrIdx  = ctrl.dstFromRs ? rsIdx : (ctrl.regDst ? rdIdx : rtIdx);
  assign wrData = ctrl.memToReg ? dmemRData : aluRes;

  assign pcPlus4  = pc + 4;
  assign brTarget = pcPlus4 + (immExt << 2);
  assign taken    = ctrl.branch && aluZero;

  always_comb begin
    if (rst)               nextPc = '0;
    else if (ctrl.jumpReg) nextPc = rsVal;
    else if (taken)        nextPc = brTarget;
    else                   nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nextPc;
  end

  assign imemAddr  = nextPc;
  assign dmemAddr  = aluRes;
  assign dmemWData = rtVal;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jumpReg && !(ctrl.branch && rsVal == rtVal)) |=> pc == $past(pc) + 4); // R12
  AST_BEQ_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rsVal == rtVal) |=> pc == $past(pc) + 4 + ($past(immExt) << 2)); // R5
  AST_JR_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctrl.jumpReg |=> pc == $past(rsVal)); // R6
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imemAddr,
  input  logic [XLEN-1:0] imemData,
  output logic [XLEN-1:0] dmemAddr,
  output logic [XLEN-1:0] dmemWData,
  input  logic [XLEN-1:0] dmemRData,
  output logic            dmemWe,
  output logic            dmemRe,
  output logic [XLEN-1:0] pc
);
  ctrl_t          ctrl;
  logic [OPW-1:0] opcode;
  logic [5:0]     funct;

  sc_control ctrl_i (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .ctrl(ctrl)
  );

  sc_datapath #(.W(XLEN)) dp_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .instr(imemData),
    .dmemRData(dmemRData), .opcode(opcode), .funct(funct), .pc(pc),
    .imemAddr(imemAddr), .dmemAddr(dmemAddr), .dmemWData(dmemWData)
  );

  assign dmemWe = ctrl.memWrite;
  assign dmemRe = ctrl.memRead;

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dmemWe && dmemRe)); // R4
endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWData, dmemRData, pc;
  logic        dmemWe, dmemRe;

  logic [31:0] rom  [64];
  logic [31:0] dmem [64];
  int checks = 0;
  int failures = 0;
  int pIdx = 0;

  always #5 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWData(dmemWData), .dmemRData(dmemRData),
    .dmemWe(dmemWe), .dmemRe(dmemRe), .pc(pc)
  );

  always @(posedge clk) imemData <= rom[imemAddr[7:2]];
  always @(posedge clk) if (dmemWe) dmem[dmemAddr[5:0]] <= dmemWData;
  assign dmemRData = dmem[dmemAddr[5:0]];

  function automatic logic [31:0] encR(int rs, int rt, int rd, int sh, int fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 64; i++) rom[i] = 32'h0;
    pIdx = 0;
  endtask
  task automatic emit(logic [31:0] w);
    rom[pIdx] = w;
    pIdx++;
  endtask
  task automatic emitHalt();
    emit(encI(6'h04, 0, 0, 16'hFFFF));
  endtask

  task automatic runProgram(int n);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    dmem[1] = 100; dmem[2] = 37; dmem[3] = 100; dmem[4] = 24;
    dmem[5] = 55; dmem[6] = 66;
    dmem[24] = 32'hFFFF; dmem[34] = 32'hFFFF; dmem[35] = 32'hFFFF;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    clearProg();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc in reset", pc, 0);
    check("R1 fetch address in reset", imemAddr, 0);
    check("R1 strobes in reset", {30'b0, dmemWe, dmemRe}, 0);
  endtask

  task automatic testPcStep();
    clearProg();
    runProgram(3);
    check("R12 R1 pc after three plain instructions", pc, 12);
  endtask

  task automatic testAlu();
    clearProg();
    emit(encI(6'h23, 0, 1, 1));
    emit(encI(6'h23, 0, 2, 2));
    emit(encR(1, 2, 3, 0, 6'h20));
    emit(encR(1, 2, 4, 0, 6'h22));
    emit(encR(1, 2, 5, 0, 6'h24));
    emit(encR(1, 2, 6, 0, 6'h25));
    emit(encR(2, 1, 7, 0, 6'h2A));
    emit(encI(6'h2B, 0, 3, 10));
    emit(encI(6'h2B, 0, 4, 11));
    emit(encI(6'h2B, 0, 5, 12));
    emit(encI(6'h2B, 0, 6, 13));
    emit(encI(6'h2B, 0, 7, 14));
    emitHalt();
    runProgram(20);
    check("R2 R3 R4 add", dmem[10], 137);
    check("R2 sub", dmem[11], 63);
    check("R2 and", dmem[12], 36);
    check("R2 or", dmem[13], 101);
    check("R2 slt", dmem[14], 1);
  endtask

  task automatic testBranch();
    clearProg();
    emit(encI(6'h23, 0, 1, 1));
    emit(encI(6'h23, 0, 2, 3));
    emit(encI(6'h04, 1, 2, 1));
    emit(encI(6'h2B, 0, 1, 20));
    emit(encI(6'h04, 1, 0, 1));
    emit(encI(6'h2B, 0, 1, 21));
    emitHalt();
    runProgram(15);
    check("R5 taken branch skips store", dmem[20], 0);
    check("R5 untaken branch falls through", dmem[21], 100);
  endtask

  task automatic testJumpReg();
    clearProg();
    emit(encI(6'h23, 0, 1, 4));
    emit(encR(1, 0, 5, 0, 6'h08));
    for (int i = 0; i < 4; i++) emit(encI(6'h2B, 0, 1, 22));
    emit(encI(6'h2B, 0, 1, 23));
    emit(encI(6'h2B, 0, 5, 24));
    emitHalt();
    runProgram(15);
    check("R6 skipped region not executed", dmem[22], 0);
    check("R6 target executed", dmem[23], 24);
    check("R6 no register write", dmem[24], 0);
  endtask

  task automatic testShiftUpper();
    clearProg();
    emit(encI(6'h23, 0, 1, 1));
    emit(encR(0, 1, 2, 3, 6'h00));
    emit(encI(6'h0F, 0, 3, 16'h1234));
    emit(encI(6'h2B, 0, 2, 25));
    emit(encI(6'h2B, 0, 3, 26));
    emitHalt();
    runProgram(12);
    check("R7 shift left by 3", dmem[25], 800);
    check("R8 upper immediate", dmem[26], 32'h1234_0000);
  endtask

  task automatic testPostInc();
    clearProg();
    emit(encI(6'h30, 4, 2, 5));
    emit(encI(6'h30, 5, 2, 5));
    emit(encI(6'h2B, 0, 4, 30));
    emit(encI(6'h2B, 0, 5, 31));
    emit(encI(6'h2B, 0, 2, 32));
    emitHalt();
    runProgram(12);
    check("R9 first loaded word", dmem[30], 55);
    check("R9 second loaded word", dmem[31], 66);
    check("R9 index stepped by one twice", dmem[32], 2);
  endtask

  task automatic testSameReg();
    clearProg();
    emit(encI(6'h30, 3, 3, 5));
    emit(encI(6'h2B, 0, 3, 33));
    emitHalt();
    runProgram(8);
    check("R10 index write wins", dmem[33], 1);
  endtask

  task automatic testZeroReg();
    clearProg();
    emit(encI(6'h23, 0, 0, 1));
    emit(encR(0, 0, 1, 0, 6'h20));
    emit(encI(6'h2B, 0, 1, 34));
    emit(encI(6'h2B, 0, 0, 35));
    emitHalt();
    runProgram(10);
    check("R11 sum of register 0", dmem[34], 0);
    check("R11 register 0 stays zero", dmem[35], 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    clearProg();
    testReset();
    testPcStep();
    testAlu();
    testBranch();
    testJumpReg();
    testShiftUpper();
    testPostInc();
    testSameReg();
    testZeroReg();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule